// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the read and write strobes for one IDE channel with two attached drives, counted in host clocks. Each access arrives on a request/accept port with a write flag, a data-port flag and a DMA flag. At acceptance the block picks one of three timing profiles: 8-bit compatible, 16-bit compatible or fast. The choice depends on the port type, the transfer type and the per-drive enables of the drive currently selected.

The selected drive comes from a shadow copy of the drive-select bit. A separate write strobe updates that shadow whenever the device's drive/head register is written. Fast timing takes an IORDY sample point and a recovery count from a primary field pair. When split timing is enabled and drive 1 is selected, it takes them from a secondary pair instead.

When IORDY checking is on for the drive, the strobe stays active until IORDY is seen high at or after the sample point. Recovery is then counted before the next request is accepted. A one-cycle done pulse marks the last strobe cycle.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset both strobes and `done` are low, `req_ack` is high and the drive-select shadow is 0.
- R2: A request is accepted in a cycle where `req` and `req_ack` are both high. The strobe rises in the next cycle: `wr_stb` if `req_wr` is 1, otherwise `rd_stb`. `req_ack` stays low until recovery ends, and the two strobes are never high together.
- R3: A request with `req_data`=0 always uses the 8-bit compatible profile (`C8_ACT` strobe cycles, `C8_REC` recovery cycles), whatever the fast-timing settings.
- R4: A data-port request for a drive whose `fast_en` bit is 0 uses the 16-bit compatible profile (`C16_ACT`, `C16_REC`).
- R5: When a drive's `fast_en` bit is 1 and its `dma_only` bit is 1, data-port requests with `req_dma`=1 use fast timing and those with `req_dma`=0 use 16-bit compatible timing. When `dma_only` is 0, both kinds use fast timing.
- R6: Fast timing takes its fields from `slv_isp`/`slv_rtc` only when `split_en`=1 and the shadow selects drive 1. In every other case it takes them from `pri_isp`/`pri_rtc`.
- R7: `dsel_wr`=1 loads `dsel_val` into the shadow at the clock edge. The shadow (bit index into `fast_en`, `dma_only`, `iordy_en`) chooses which drive's enables apply. Reset returns it to drive 0.
- R8: The fast sample-point field sets the strobe width with no stall: code 00 gives 5 clocks, 01 gives 4, 10 gives 3, 11 gives 2.
- R9: The fast recovery field sets the number of cycles with `req_ack` low after the strobe ends: 00 gives 4, 01 gives 3, 10 gives 2, 11 gives 1.
- R10: When the selected drive's `iordy_en` bit is 1, the strobe stays high past its sample point for as long as `iordy` is low. It ends in the first cycle at or after the sample point where `iordy` is high, and recovery counts from there.
- R11: When the selected drive's `iordy_en` bit is 0, `iordy` has no effect on strobe width.
- R12: `done` is a one-cycle pulse in the last strobe-high cycle of each access. `done_rd` equals `done` on reads and stays 0 on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_en | input | 1 | Enables the secondary fast-timing fields for drive 1 |
| pri_isp | input | 2 | Primary IORDY sample-point code |
| pri_rtc | input | 2 | Primary recovery code |
| slv_isp | input | 2 | Secondary IORDY sample-point code |
| slv_rtc | input | 2 | Secondary recovery code |
| fast_en | input | 2 | Per-drive fast-timing enable, bit n for drive n |
| dma_only | input | 2 | Per-drive fast-for-DMA-only option |
| iordy_en | input | 2 | Per-drive IORDY checking enable |
| dsel_wr | input | 1 | Drive/head register write seen on the bus |
| dsel_val | input | 1 | Drive-select bit of that write |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data port, 0 = other command-block port |
| req_dma | input | 1 | 1 = DMA transfer, 0 = PIO |
| req_ack | output | 1 | Ready to accept a request this cycle |
| iordy | input | 1 | Device ready, high = ready |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| done | output | 1 | Last strobe cycle of an access |
| done_rd | output | 1 | Done pulse of a read access |

## Verification
The assertions check, on every cycle, that the strobes never overlap and that an accepted request is followed by a strobe. They also check that a low IORDY past the sample point holds the strobe, and that done falls exactly at the strobe's final cycle and marks reads only. Only the bench scenarios show the clock-exact widths and recovery gaps of each profile. The same holds for the drive-select, split, DMA-only and port-type decisions behind them, that IORDY is ignored when disabled, and that reset returns the shadow to drive 0.

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
  parameter int CW      = 4,
  parameter int C16_ACT = 6,
  parameter int C16_REC = 5,
  parameter int C8_ACT  = 8,
  parameter int C8_REC  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       split_en,
  input  logic [1:0] pri_isp,
  input  logic [1:0] pri_rtc,
  input  logic [1:0] slv_isp,
  input  logic [1:0] slv_rtc,
  input  logic [1:0] fast_en,
  input  logic [1:0] dma_only,
  input  logic [1:0] iordy_en,
  input  logic       dsel_wr,
  input  logic       dsel_val,
  input  logic       req,
  input  logic       req_wr,
  input  logic       req_data,
  input  logic       req_dma,
  output logic       req_ack,
  input  logic       iordy,
  output logic       rd_stb,
  output logic       wr_stb,
  output logic       done,
  output logic       done_rd
);

  typedef enum logic [1:0] {S_IDLE, S_STB, S_REC} st_t;

  st_t           st;
  logic          dsel;
  logic          wr_q, ien_q;
  logic [CW-1:0] act_q, rec_q, cnt;

  wire           use_slv  = split_en & dsel;
  wire [1:0]     isp_code = use_slv ? slv_isp : pri_isp;
  wire [1:0]     rtc_code = use_slv ? slv_rtc : pri_rtc;
  wire [CW-1:0]  fast_act = CW'(5) - CW'(isp_code);
  wire [CW-1:0]  fast_rec = CW'(4) - CW'(rtc_code);
  wire           go_fast  = req_data & fast_en[dsel] & (req_dma | ~dma_only[dsel]);

  wire [CW-1:0]  sel_act  = !req_data ? CW'(C8_ACT) : go_fast ? fast_act : CW'(C16_ACT);
  wire [CW-1:0]  sel_rec  = !req_data ? CW'(C8_REC) : go_fast ? fast_rec : CW'(C16_REC);

  assign req_ack = (st == S_IDLE);
  wire   accept  = req & req_ack;
  wire   in_stb  = (st == S_STB);
  wire   finish  = in_stb && (cnt >= act_q) && (iordy || !ien_q);

  assign rd_stb  = in_stb & ~wr_q;
  assign wr_stb  = in_stb & wr_q;
  assign done    = finish;
  assign done_rd = finish & ~wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsel <= 1'b0;
    end else if (dsel_wr) begin
      dsel <= dsel_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      act_q <= '0;
      rec_q <= '0;
      wr_q  <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          st    <= S_STB;
          cnt   <= CW'(1);
          act_q <= sel_act;
          rec_q <= sel_rec;
          wr_q  <= req_wr;
          ien_q <= iordy_en[dsel];
        end
        S_STB: begin
          if (finish) begin
            st  <= S_REC;
            cnt <= CW'(1);
          end else if (cnt < act_q) begin
            cnt <= cnt + CW'(1);
          end
        end
        S_REC: begin
          if (cnt >= rec_q) st <= S_IDLE;
          else              cnt <= cnt + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  // R2
  ack_starts_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_ack) |=> (rd_stb || wr_stb));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && ien_q && !iordy && cnt >= act_q) |=> (rd_stb || wr_stb));

  // R12
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !(rd_stb || wr_stb));

  // R12
  done_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_rd |-> (done && rd_stb));

endmodule

// File: tb/ide_pio_timer_tb.sv
module ide_pio_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic split_en = 0;
  logic [1:0] pri_isp = 2'b01, pri_rtc = 2'b10, slv_isp = 2'b11, slv_rtc = 2'b00;
  logic [1:0] fast_en = 0, dma_only = 0, iordy_en = 0;
  logic dsel_wr = 0, dsel_val = 0;
  logic req = 0, req_wr = 0, req_data = 0, req_dma = 0, iordy = 1;
  logic req_ack, rd_stb, wr_stb, done, done_rd;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ide_pio_timer dut_i (
    .clk(clk), .rst_n(rst_n), .split_en(split_en),
    .pri_isp(pri_isp), .pri_rtc(pri_rtc), .slv_isp(slv_isp), .slv_rtc(slv_rtc),
    .fast_en(fast_en), .dma_only(dma_only), .iordy_en(iordy_en),
    .dsel_wr(dsel_wr), .dsel_val(dsel_val),
    .req(req), .req_wr(req_wr), .req_data(req_data), .req_dma(req_dma),
    .req_ack(req_ack), .iordy(iordy), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .done(done), .done_rd(done_rd));

  typedef struct packed {
    bit s, d, f, o, dat, dma, wr, ien;
    bit [3:0] st, ew, er;
  } vec_t;

  // split, drive, fast, dma_only, data, dma, wr, iordy_en, stall, width, recovery
  localparam vec_t VEC [14] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd6,4'd5},  // R4
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'd0,4'd4,4'd2},  // R5 fast PIO
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,4'd6,4'd5},  // R5 PIO compat
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'd0,4'd4,4'd2},  // R5 DMA fast
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd0,4'd8,4'd7},  // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd4,4'd2},  // R6 split off
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd2,4'd4},  // R6 slave fields
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,4'd0,4'd4,4'd2},  // R6 drive 0 primary
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'd0,4'd6,4'd5},  // R7 drive 1 bits
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,4'd3,4'd5,4'd4},  // R10
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'd4,4'd10,4'd5}, // R10 compat
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd3,4'd4,4'd2},  // R11
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,4'd2,4'd10,4'd7}, // R3 R10
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd0,4'd6,4'd5}   // R5 R7
  };

  task automatic check(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic access(input vec_t v, input bit set_dsel, input int id);
    int width, rec, ndone, nrd, badstb;
    if (set_dsel) begin
      @(negedge clk); dsel_wr = 1; dsel_val = v.d;
      @(negedge clk); dsel_wr = 0;
    end
    split_en = v.s;
    fast_en[v.d] = v.f;    fast_en[!v.d] = !v.f;
    dma_only[v.d] = v.o;   dma_only[!v.d] = !v.o;
    iordy_en[v.d] = v.ien; iordy_en[!v.d] = !v.ien;
    @(negedge clk);
    iordy = (v.st == 0);
    req = 1; req_wr = v.wr; req_data = v.dat; req_dma = v.dma;
    @(negedge clk);
    req = 0;
    width = 0; ndone = 0; nrd = 0; badstb = 0;
    while ((rd_stb || wr_stb) && width < 40) begin
      width++;
      if (width >= int'(v.ew) && width >= 1) iordy = 1;
      if (width >= 1 && v.st != 0 && width >= int'(v.ew)) iordy = 1;
      #1;
      if (rd_stb == v.wr || wr_stb != v.wr) badstb++;
      if (done) ndone++;
      if (done_rd) nrd++;
      @(negedge clk);
    end
    rec = 0;
    while (!req_ack && rec < 40) begin
      rec++;
      @(negedge clk);
    end
    iordy = 1;
    check($sformatf("R8 R10 R11 strobe width vec %0d", id), width, v.ew);
    check($sformatf("R9 recovery vec %0d", id), rec, v.er);
    check($sformatf("R12 done pulses vec %0d", id), ndone, 1);
    check($sformatf("R12 done_rd pulses vec %0d", id), nrd, v.wr ? 0 : 1);
    check($sformatf("R2 strobe kind vec %0d", id), badstb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 rd_stb at reset", rd_stb, 0);
    check("R1 wr_stb at reset", wr_stb, 0);
    check("R1 done at reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 req_ack after reset", req_ack, 1);
    // R7: shadow starts at drive 0 without any write
    access('{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd4,4'd2}, 0, 100);
    for (int i = 0; i < 14; i++) access(VEC[i], 1, i);
    // R8 R9: every code of both fields
    for (int c = 0; c < 4; c++) begin
      vec_t v;
      pri_isp = 2'(c); pri_rtc = 2'(c);
      v = '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'd0,4'(5-c),4'(4-c)};
      access(v, 1, 200 + c);
    end
    pri_isp = 2'b01; pri_rtc = 2'b10;
    // R7: reset returns shadow to drive 0
    @(negedge clk); dsel_wr = 1; dsel_val = 1;
    @(negedge clk); dsel_wr = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    access('{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd4,4'd2}, 0, 300);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule